// File: doc/BRIEF.md
# Ping-Pong Audio Playback Buffer

This block holds audio samples in a memory split into two equal halves. A host fills the memory through a word-addressed port on the bus clock. A playback engine on its own clock reads one 32-bit sample per sample tick and hands it to the DAC interface. The engine walks the two halves as one circular region and never stops or waits. It moves from one half into the other on its own timing, whether or not the host has refilled that half.

Each crossing between halves bumps a period counter. The host learns which half is idle by polling a status word. That word carries a fixed marker byte, the period count and the next word address the engine will play. The count and the address come from one free-running counter, which crosses into the bus domain as a Gray code. Both host ports behave as plain memory, so their empty, full and end-of-stream flags never assert.

Top module: `pingpong_playback_buf`

## Requirements
- R1: After reset, `dac_valid_o` is low, the next word to play is address 0 and the period count is 0, so a status read returns 0xAC in bits [31:24] and zero in every other bit.
- R2: A `tick_i` sampled high on a `play_clk_i` edge makes `dac_data_o` carry the word at the current play address, with `dac_valid_o` high for the next `play_clk_i` cycle only; the play address then advances by one.
- R3: When `tick_i` is low on a `play_clk_i` edge, the play address and period count do not change, and `dac_valid_o` is low in the following cycle.
- R4: The play address runs through the whole memory of 2*HALF_WORDS words and wraps from the last word back to word 0, replaying whatever each word holds without regard to host activity.
- R5: The period count goes up by one each time the play address moves from HALF_WORDS-1 to HALF_WORDS and from the last word to 0, and wraps modulo 2^PERIOD_W.
- R6: The status word holds 0xAC in bits [31:24], zeros below it down to the period field, the period count in the PERIOD_W bits starting at bit AW, and the next play address in bits [AW-1:0], where AW = log2(2*HALF_WORDS) (12 by default, so the period sits in bits [19:12]).
- R7: The status word appears on `stat_rd_data_o` one bus cycle after `stat_rd_en_i` is sampled high and holds its value while `stat_rd_en_i` is low.
- R8: A host write with `mem_wr_en_i` high stores `mem_wr_data_i` at `mem_addr_i`; a host read with `mem_rd_en_i` high returns the word at `mem_addr_i` one bus cycle later, returns the old contents when a write hits the same address in the same cycle, and holds while `mem_rd_en_i` is low.
- R9: `rd_empty_o`, `wr_full_o` and `rd_eof_o` are always low.
- R10: The play count crosses to the bus domain as a registered Gray code that changes at most one bit per `play_clk_i` cycle; once ticks stop, the status word shows the exact count within two play cycles plus SYNC_STAGES+1 bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Host bus clock |
| play_clk_i | input | 1 | Playback clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| tick_i | input | 1 | Sample tick, one play-clock cycle per sample |
| mem_addr_i | input | AW | Host word address for read and write |
| mem_wr_en_i | input | 1 | Host write enable |
| mem_wr_data_i | input | 32 | Host write data |
| mem_rd_en_i | input | 1 | Host read enable |
| mem_rd_data_o | output | 32 | Host read data, one cycle after enable |
| stat_rd_en_i | input | 1 | Status read enable |
| stat_rd_data_o | output | 32 | Status word: marker, period count, play address |
| rd_empty_o | output | 1 | Host read-side empty flag, held low |
| wr_full_o | output | 1 | Host write-side full flag, held low |
| rd_eof_o | output | 1 | Host end-of-stream flag, held low |
| dac_data_o | output | 32 | Sample to the DAC interface |
| dac_valid_o | output | 1 | One-cycle strobe per played sample |

## Verification
A wrong play address shows up on `dac_data_o` at the very next tick as a sample from the wrong word, because every word holds a distinct value and each strobe is compared with the model. A counter that skips or stalls also leaves the status word off by a fixed amount at the next quiet poll, a few bus cycles later. A broken Gray crossing or a misplaced field shows as a bad period or address field at that same poll. The period wrap is reached with a small HALF_WORDS, so a wrong field width also shows within a few thousand ticks.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  localparam logic [7:0] STAT_MARK = 8'hAC;
  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/ppb_sample_mem.sv
module ppb_sample_mem #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          bus_clk_i,
  input  logic          play_clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_wr_en_i,
  input  logic [DW-1:0] host_wr_data_i,
  input  logic          host_rd_en_i,
  output logic [DW-1:0] host_rd_data_o,
  input  logic          play_en_i,
  input  logic [AW-1:0] play_addr_i,
  output logic [DW-1:0] play_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge bus_clk_i) begin
    if (host_wr_en_i) mem_q[host_addr_i] <= host_wr_data_i;
  end

  // read-first: reads see contents before a same-cycle write
  always_ff @(posedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni)           host_rd_data_o <= '0;
    else if (host_rd_en_i) host_rd_data_o <= mem_q[host_addr_i];
  end

  always_ff @(posedge play_clk_i or negedge rst_ni) begin
    if (!rst_ni)        play_data_o <= '0;
    else if (play_en_i) play_data_o <= mem_q[play_addr_i];
  end

  assert_rd_hold_R8: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !host_rd_en_i |=> $stable(host_rd_data_o));
endmodule

// File: rtl/ppb_play_ctrl.sv
module ppb_play_ctrl #(
  parameter int unsigned AW       = 12,
  parameter int unsigned PERIOD_W = 8,
  localparam int unsigned CNT_W   = PERIOD_W + AW - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic             rd_en_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_gray_o
);
  // low AW bits: play address; upper bits: half count (= period count)
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  // registered so the crossing sees glitch-free single-bit steps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_gray_o <= '0;
    else         cnt_gray_o <= cnt_q ^ (cnt_q >> 1);
  end

  assign rd_addr_o = cnt_q[AW-1:0];
  assign rd_en_o   = tick_i;

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_strobe_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
  assert_gray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cnt_gray_o ^ $past(cnt_gray_o)) <= 1);
endmodule

// File: rtl/ppb_gray_sync.sv
module ppb_gray_sync #(
  parameter int unsigned W      = 19,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= gray_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  always_comb begin
    bin_o[W-1] = stg_q[STAGES-1][W-1];
    for (int i = int'(W) - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ stg_q[STAGES-1][i];
  end
endmodule

// File: rtl/ppb_status.sv
module ppb_status #(
  parameter int unsigned AW       = 12,
  parameter int unsigned PERIOD_W = 8,
  localparam int unsigned CNT_W   = PERIOD_W + AW - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_en_i,
  output logic [31:0]      data_o
);
  logic [PERIOD_W-1:0] period;
  logic [AW-1:0]       pos;
  logic [23:0]         low_word;

  assign period   = cnt_i[CNT_W-1:AW-1];
  assign pos      = cnt_i[AW-1:0];
  assign low_word = (24'(period) << AW) | 24'(pos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (rd_en_i) data_o <= {ppb_pkg::STAT_MARK, low_word};
  end

  assert_stat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(data_o));
endmodule

// File: rtl/pingpong_playback_buf.sv
module pingpong_playback_buf #(
  parameter int unsigned HALF_WORDS  = 2048,
  parameter int unsigned PERIOD_W    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DEPTH      = 2 * HALF_WORDS,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned CNT_W      = PERIOD_W + AW - 1,
  localparam int unsigned DW         = ppb_pkg::WORD_W
) (
  input  logic          bus_clk_i,
  input  logic          play_clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] mem_addr_i,
  input  logic          mem_wr_en_i,
  input  logic [DW-1:0] mem_wr_data_i,
  input  logic          mem_rd_en_i,
  output logic [DW-1:0] mem_rd_data_o,
  input  logic          stat_rd_en_i,
  output logic [31:0]   stat_rd_data_o,
  output logic          rd_empty_o,
  output logic          wr_full_o,
  output logic          rd_eof_o,
  output logic [DW-1:0] dac_data_o,
  output logic          dac_valid_o
);
  logic [AW-1:0]    play_addr;
  logic             play_en;
  logic [CNT_W-1:0] cnt_gray;
  logic [CNT_W-1:0] cnt_bus;

  ppb_sample_mem #(.DEPTH(DEPTH), .DW(DW)) i_mem (
    .bus_clk_i     (bus_clk_i),
    .play_clk_i    (play_clk_i),
    .rst_ni        (rst_ni),
    .host_addr_i   (mem_addr_i),
    .host_wr_en_i  (mem_wr_en_i),
    .host_wr_data_i(mem_wr_data_i),
    .host_rd_en_i  (mem_rd_en_i),
    .host_rd_data_o(mem_rd_data_o),
    .play_en_i     (play_en),
    .play_addr_i   (play_addr),
    .play_data_o   (dac_data_o)
  );

  ppb_play_ctrl #(.AW(AW), .PERIOD_W(PERIOD_W)) i_play (
    .clk_i     (play_clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rd_addr_o (play_addr),
    .rd_en_o   (play_en),
    .valid_o   (dac_valid_o),
    .cnt_gray_o(cnt_gray)
  );

  ppb_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (bus_clk_i),
    .rst_ni(rst_ni),
    .gray_i(cnt_gray),
    .bin_o (cnt_bus)
  );

  ppb_status #(.AW(AW), .PERIOD_W(PERIOD_W)) i_stat (
    .clk_i  (bus_clk_i),
    .rst_ni (rst_ni),
    .cnt_i  (cnt_bus),
    .rd_en_i(stat_rd_en_i),
    .data_o (stat_rd_data_o)
  );

  // memory-mapped host ports: never empty, full or at end of stream
  assign rd_empty_o = 1'b0;
  assign wr_full_o  = 1'b0;
  assign rd_eof_o   = 1'b0;
endmodule

// File: tb/test_pingpong_playback_buf.sv
`timescale 1ns/1ps
module test_pingpong_playback_buf;
  localparam int HALF  = 16;
  localparam int DEPTH = 2 * HALF;
  localparam int AW    = $clog2(DEPTH);

  logic bus_clk = 1'b0, play_clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, st_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, st_data, dac_data;
  logic empty, full, eof, dac_valid;

  always #2 bus_clk = ~bus_clk;
  always #5 play_clk = ~play_clk;

  pingpong_playback_buf #(.HALF_WORDS(HALF)) i_pingpong_playback_buf (
    .bus_clk_i(bus_clk), .play_clk_i(play_clk), .rst_ni(rst_n), .tick_i(tick),
    .mem_addr_i(addr), .mem_wr_en_i(wr_en), .mem_wr_data_i(wr_data),
    .mem_rd_en_i(rd_en), .mem_rd_data_o(rd_data),
    .stat_rd_en_i(st_en), .stat_rd_data_o(st_data),
    .rd_empty_o(empty), .wr_full_o(full), .rd_eof_o(eof),
    .dac_data_o(dac_data), .dac_valid_o(dac_valid)
  );

  int total = 0, bad = 0;
  logic [31:0] mem_m [DEPTH];
  int cnt_m = 0;
  bit run = 0;
  int gap = 1, phase = 0;
  bit pend_v = 0;
  logic [31:0] pend_d = '0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_stat(int c);
    return (32'hAC << 24) | (32'((c / HALF) % 256) << AW) | 32'(c % DEPTH);
  endfunction

  // tick driver: after each play edge
  always @(posedge play_clk) begin
    #2;
    if (run) begin
      tick = (phase % gap) == 0;
      phase++;
    end else tick = 1'b0;
  end

  // reference model for playback, compared every play cycle (R2, R3, R4)
  always @(negedge play_clk) begin
    chk(dac_valid === pend_v, "R2/R3 valid", 32'(dac_valid), 32'(pend_v));
    if (pend_v) chk(dac_data === pend_d, "R2/R4 data", dac_data, pend_d);
    pend_v = tick;
    if (tick) begin
      pend_d = mem_m[cnt_m % DEPTH];
      cnt_m++;
    end
  end

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge bus_clk);
    addr = AW'(a); wr_data = d; wr_en = 1'b1;
    mem_m[a] = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(int a);
    @(negedge bus_clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge bus_clk);
    rd_en = 1'b0;
    chk(rd_data === mem_m[a], "R8 read", rd_data, mem_m[a]);
  endtask

  task automatic quiesce();
    run = 0;
    repeat (3) @(negedge play_clk);
    repeat (6) @(negedge bus_clk);
  endtask

  task automatic stat_read(string req);
    @(negedge bus_clk);
    st_en = 1'b1;
    @(negedge bus_clk);
    st_en = 1'b0;
    chk(st_data === exp_stat(cnt_m), req, st_data, exp_stat(cnt_m));
  endtask

  task automatic play_n(int n, int g);
    int target;
    target = cnt_m + n;
    gap = g; phase = 0; run = 1;
    while (cnt_m < target) @(negedge play_clk);
    quiesce();
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held, old_word;
    #33 rst_n = 1'b1;
    // R1 reset state and R9 flags
    repeat (4) @(negedge bus_clk);
    chk(dac_valid === 1'b0, "R1 valid", 32'(dac_valid), 32'd0);
    chk({empty, full, eof} === 3'b000, "R9 flags", 32'({empty, full, eof}), 32'd0);
    stat_read("R1/R6 reset status");

    // fill both halves with distinct words
    for (int i = 0; i < DEPTH; i++) bus_write(i, 32'h5A00_0000 + 32'(i) * 32'h0001_0103);
    bus_read(0); bus_read(HALF - 1); bus_read(HALF); bus_read(DEPTH - 1);
    held = rd_data;
    repeat (3) @(negedge bus_clk);
    chk(rd_data === held, "R8 hold", rd_data, held);

    // R8 read-first on same-cycle write
    @(negedge bus_clk);
    addr = AW'(5); wr_data = 32'hDEAD_0005; wr_en = 1'b1; rd_en = 1'b1;
    old_word = mem_m[5];
    @(negedge bus_clk);
    wr_en = 1'b0; rd_en = 1'b0; mem_m[5] = 32'hDEAD_0005;
    chk(rd_data === old_word, "R8 read-first", rd_data, old_word);
    bus_read(5);

    // back-to-back ticks across the half boundary (R2, R5, R6, R10)
    play_n(HALF + 3, 1);
    stat_read("R5/R6/R10 after first boundary");
    // sparse ticks, full wrap of the address (R3, R4)
    play_n(DEPTH, 3);
    stat_read("R4/R10 after address wrap");

    // R7 status hold while playback runs
    held = st_data;
    gap = 2; phase = 0; run = 1;
    repeat (10) @(negedge bus_clk);
    chk(st_data === held, "R7 stat hold", st_data, held);
    repeat (10) @(negedge bus_clk);
    chk(st_data === held, "R7 stat hold late", st_data, held);
    quiesce();
    stat_read("R7 status after hold");

    // host rewrites idle half while stopped; replay shows new data (R4)
    for (int i = 0; i < HALF; i++) bus_write(i, 32'hC300_0000 + 32'(i));
    play_n(DEPTH + 2, 1);
    stat_read("R4 after refill");

    // R5 period wrap modulo 256
    play_n(256 * HALF - (cnt_m % (256 * HALF)) + 7, 1);
    stat_read("R5 period wrap");
    chk(cnt_m / HALF >= 256, "R5 wrap reached", 32'(cnt_m), 32'(256 * HALF));

    chk({empty, full, eof} === 3'b000, "R9 flags end", 32'({empty, full, eof}), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule